// File: doc/BRIEF.md
# Low-Power Mode Entry Clock Sequencer

This block carries out the closing steps of a mode change inside a chip-level mode controller. When the earlier stage of the transition reports that it has finished, the sequencer receives the target mode and works out which peripherals must be quiet in that mode. It sends each such peripheral a stop request and turns off that peripheral's clock once the peripheral acknowledges. For the SAFE target it does not wait: the clock pattern for SAFE applies at once. For the three low-power targets it then asks the processor to halt (HALT) or to stop (STOP, STANDBY). Once the processor confirms the matching state, it gates the processor and system-memory clock. A wake input undoes the processor side, and the peripheral clocks follow whatever the next mode transition selects.

Each peripheral's behaviour per mode comes from a small configuration store with one write port. There are eight running-mode sets, each holding one enable bit per running mode. There are eight low-power sets, each holding one enable bit per low-power mode. Each peripheral has a control entry that picks one set of each kind.

Top module: `lpm_clk_seq`

## Requirements
- R1: After reset, every peripheral clock enable and the core clock enable are 1, all stop and halt requests are 0, and done is 0. Every configuration set reads as all-enabled, and every control entry selects set 0.
- R2: Mode codes are SAFE=0, DRUN=1, RUN0..RUN3=2..5, HALT=6, STOP=7 and STANDBY=8. Peripheral p is enabled in a running mode m when bit m of the running set chosen by its control entry is 1. It is enabled in a low-power mode m when bit m-6 of the chosen low-power set is 1.
- R3: In the cycle after an accepted start, a peripheral that is enabled in the target has its clock enable at 1 and its stop request at 0. A disabled peripheral whose clock is running has its stop request at 1. A disabled peripheral whose clock is already off is not requested again.
- R4: For a target other than SAFE, a requested peripheral's clock enable falls only in the cycle after a clock edge at which its stop request and its acknowledge are both 1.
- R5: For the SAFE target, every peripheral disabled in SAFE has its clock enable at 0 in the cycle after start, whatever its acknowledge.
- R6: For a running-mode target, done is a single-cycle pulse. It appears in the cycle after the edge at which no running, requested peripheral still lacks an acknowledge. Neither processor request is raised, and the core clock stays on.
- R7: For a low-power target, the processor request is raised only after the peripheral phase completes: halt for HALT, stop for STOP or STANDBY. The two processor requests are never both 1.
- R8: The core clock enable falls, and done pulses, in the cycle after the acknowledge that matches the raised request. The other acknowledge has no effect.
- R9: When wake is asserted while the processor request is pending or the core clock is off, the next cycle shows both processor requests at 0 and the core clock at 1. Peripheral clock enables are unchanged until the next start.
- R10: A start with a mode code above 8, or a start while a sequence is in progress, is ignored.
- R11: The configuration write port writes a running set (kind 0, set index in addr[2:0], 6-bit mask), a low-power set (kind 1, 3-bit mask in wdata[2:0]) or a control entry (kind 2, addr is the peripheral, wdata[2:0] is the running set, wdata[5:3] is the low-power set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 running set, 1 low-power set, 2 control entry |
| cfg_addr | input | ADDR_W | Set index or peripheral index |
| cfg_wdata | input | 6 | Write data |
| start | input | 1 | Previous transition step has finished |
| target_mode | input | 4 | Target mode code |
| periph_ack | input | NUM_PERIPH | Per-peripheral stop acknowledge |
| cpu_halt_ack | input | 1 | Processor is halted |
| cpu_stop_ack | input | 1 | Processor is stopped |
| wake | input | 1 | Exit from low-power mode |
| periph_stop_req | output | NUM_PERIPH | Per-peripheral stop request |
| periph_clk_en | output | NUM_PERIPH | Per-peripheral clock enable |
| cpu_halt_req | output | 1 | Halt request to processor |
| cpu_stop_req | output | 1 | Stop request to processor |
| core_clk_en | output | 1 | Processor and system-memory clock enable |
| done | output | 1 | Sequence complete pulse |

## Verification
The configuration store is filled with random masks and selections, and a long run of random target modes follows. Each peripheral's clock enable and request are compared with a model after every transition. Random acknowledge delays show that gating waits for acknowledges on ordinary targets and ignores them on SAFE. Running the same sequence against HALT, STOP and STANDBY shows that the request type and core gating follow the mode. Directed cases cover the wrong processor acknowledge, a start while busy, an invalid mode code, and wake. Between them they separate a missing wait, a wrong request type and a premature restore.

// File: rtl/lpm_seq_pkg.sv
package lpm_seq_pkg;

    localparam int RUN_MODES = 6;
    localparam int LP_MODES  = 3;
    localparam int CFG_SETS  = 8;
    localparam int SEL_W     = $clog2(CFG_SETS);
    localparam int CFG_DW    = RUN_MODES;

    typedef enum logic [3:0] {
        MD_SAFE    = 4'd0,
        MD_DRUN    = 4'd1,
        MD_RUN0    = 4'd2,
        MD_RUN1    = 4'd3,
        MD_RUN2    = 4'd4,
        MD_RUN3    = 4'd5,
        MD_HALT    = 4'd6,
        MD_STOP    = 4'd7,
        MD_STANDBY = 4'd8
    } mode_e;

    typedef enum logic [1:0] {
        CFG_RUN_SET = 2'd0,
        CFG_LP_SET  = 2'd1,
        CFG_PCTL    = 2'd2
    } cfg_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_PERIPH = 2'd1,
        SQ_CPU    = 2'd2,
        SQ_HOLD   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [SEL_W-1:0] lp_sel;
        logic [SEL_W-1:0] run_sel;
    } pctl_t;

    function automatic logic mode_valid(input logic [3:0] m);
        return m <= 4'd8;
    endfunction

    function automatic logic mode_is_lp(input logic [3:0] m);
        return (m >= 4'd6) && (m <= 4'd8);
    endfunction

    function automatic logic [1:0] lp_index(input logic [3:0] m);
        logic [3:0] d;
        d = m - 4'd6;
        return d[1:0];
    endfunction

endpackage

// File: rtl/lpm_cfg_store.sv
module lpm_cfg_store
    import lpm_seq_pkg::*;
#(
    parameter int NUM_PERIPH = 144,
    parameter int ADDR_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_kind,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [CFG_DW-1:0]     cfg_wdata,
    input  logic [3:0]            mode,
    output logic [NUM_PERIPH-1:0] en_vec
);

    logic [RUN_MODES-1:0] run_set [CFG_SETS];
    logic [LP_MODES-1:0]  lp_set  [CFG_SETS];
    pctl_t                pctl    [NUM_PERIPH];

    logic [SEL_W-1:0] set_idx;
    assign set_idx = cfg_addr[SEL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < CFG_SETS; s++) begin
                run_set[s] <= '1;
                lp_set[s]  <= '1;
            end
            for (int p = 0; p < NUM_PERIPH; p++) begin
                pctl[p] <= '0;
            end
        end else if (cfg_we) begin
            case (cfg_kind_e'(cfg_kind))
                CFG_RUN_SET: run_set[set_idx] <= cfg_wdata[RUN_MODES-1:0];
                CFG_LP_SET:  lp_set[set_idx]  <= cfg_wdata[LP_MODES-1:0];
                CFG_PCTL: begin
                    for (int p = 0; p < NUM_PERIPH; p++) begin
                        if (int'(cfg_addr) == p) begin
                            pctl[p] <= pctl_t'(cfg_wdata[2*SEL_W-1:0]);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    logic       is_lp;
    logic [1:0] lp_bit;
    assign is_lp  = mode_is_lp(mode);
    assign lp_bit = lp_index(mode);

    for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_en
        logic [RUN_MODES-1:0] rmask;
        logic [LP_MODES-1:0]  lmask;
        always_comb begin
            rmask = run_set[pctl[p].run_sel];
            lmask = lp_set[pctl[p].lp_sel];
            if (is_lp) begin
                en_vec[p] = (lp_bit < 2'(LP_MODES)) ? lmask[lp_bit] : 1'b1;
            end else if (mode < 4'(RUN_MODES)) begin
                en_vec[p] = rmask[mode[2:0]];
            end else begin
                en_vec[p] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lpm_periph_gate.sv
module lpm_periph_gate #(
    parameter int NUM_PERIPH = 144
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  safe,
    input  logic [NUM_PERIPH-1:0] en_vec,
    input  logic [NUM_PERIPH-1:0] ack,
    output logic [NUM_PERIPH-1:0] stop_req,
    output logic [NUM_PERIPH-1:0] clk_en,
    output logic                  pending
);

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_p
        always_ff @(posedge clk) begin
            if (rst) begin
                stop_req[i] <= 1'b0;
                clk_en[i]   <= 1'b1;
            end else if (load) begin
                if (en_vec[i]) begin
                    stop_req[i] <= 1'b0;
                    clk_en[i]   <= 1'b1;
                end else begin
                    stop_req[i] <= stop_req[i] | clk_en[i];
                    if (safe) clk_en[i] <= 1'b0;
                end
            end else if (stop_req[i] && ack[i]) begin
                clk_en[i] <= 1'b0;
            end
        end

        AST_GATE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
            $fell(clk_en[i]) |-> ($past(load) && $past(safe)) || $past(stop_req[i] && ack[i])); // R4
        AST_SAFE_NOW: assert property (@(posedge clk) disable iff (rst)
            (load && safe && !en_vec[i]) |=> !clk_en[i]); // R5
        AST_ENABLED_KEPT: assert property (@(posedge clk) disable iff (rst)
            (load && en_vec[i]) |=> (clk_en[i] && !stop_req[i])); // R3
    end

    assign pending = |(stop_req & clk_en & ~ack);

endmodule

// File: rtl/lpm_seq_fsm.sv
module lpm_seq_fsm
    import lpm_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [3:0] target_mode,
    input  logic       pending,
    input  logic       cpu_halt_ack,
    input  logic       cpu_stop_ack,
    input  logic       wake,
    output logic       load,
    output logic       safe,
    output logic       cpu_halt_req,
    output logic       cpu_stop_req,
    output logic       core_clk_en,
    output logic       done
);

    seq_state_e state;
    logic [3:0] mode_q;
    logic       cpu_match;

    assign load      = start && (state == SQ_IDLE) && mode_valid(target_mode);
    assign safe      = (target_mode == 4'(MD_SAFE));
    assign cpu_match = (cpu_halt_req && cpu_halt_ack) || (cpu_stop_req && cpu_stop_ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= SQ_IDLE;
            mode_q       <= 4'(MD_SAFE);
            cpu_halt_req <= 1'b0;
            cpu_stop_req <= 1'b0;
            core_clk_en  <= 1'b1;
            done         <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (load) begin
                        mode_q <= target_mode;
                        state  <= SQ_PERIPH;
                    end
                end
                SQ_PERIPH: begin
                    if (!pending) begin
                        if (mode_is_lp(mode_q)) begin
                            cpu_halt_req <= (mode_q == 4'(MD_HALT));
                            cpu_stop_req <= (mode_q != 4'(MD_HALT));
                            state        <= SQ_CPU;
                        end else begin
                            done  <= 1'b1;
                            state <= SQ_IDLE;
                        end
                    end
                end
                SQ_CPU: begin
                    if (wake) begin
                        cpu_halt_req <= 1'b0;
                        cpu_stop_req <= 1'b0;
                        state        <= SQ_IDLE;
                    end else if (cpu_match) begin
                        core_clk_en <= 1'b0;
                        done        <= 1'b1;
                        state       <= SQ_HOLD;
                    end
                end
                SQ_HOLD: begin
                    if (wake) begin
                        cpu_halt_req <= 1'b0;
                        cpu_stop_req <= 1'b0;
                        core_clk_en  <= 1'b1;
                        state        <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    AST_ONE_CPU_REQ: assert property (@(posedge clk) disable iff (rst)
        !(cpu_halt_req && cpu_stop_req)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6
    AST_CORE_OFF_ONLY_LP: assert property (@(posedge clk) disable iff (rst)
        !core_clk_en |-> mode_is_lp(mode_q)); // R8
    AST_CORE_OFF_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(core_clk_en) |-> $past(cpu_match)); // R8
    AST_WAKE_RESTORES: assert property (@(posedge clk) disable iff (rst)
        (wake && (state == SQ_HOLD)) |=> (core_clk_en && !cpu_halt_req && !cpu_stop_req)); // R9

endmodule

// File: rtl/lpm_clk_seq.sv
module lpm_clk_seq
    import lpm_seq_pkg::*;
#(
    parameter int NUM_PERIPH = 144,
    parameter int ADDR_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_kind,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [5:0]            cfg_wdata,
    input  logic                  start,
    input  logic [3:0]            target_mode,
    input  logic [NUM_PERIPH-1:0] periph_ack,
    input  logic                  cpu_halt_ack,
    input  logic                  cpu_stop_ack,
    input  logic                  wake,
    output logic [NUM_PERIPH-1:0] periph_stop_req,
    output logic [NUM_PERIPH-1:0] periph_clk_en,
    output logic                  cpu_halt_req,
    output logic                  cpu_stop_req,
    output logic                  core_clk_en,
    output logic                  done
);

    logic [NUM_PERIPH-1:0] en_vec;
    logic                  load;
    logic                  safe;
    logic                  pending;

    lpm_cfg_store #(.NUM_PERIPH(NUM_PERIPH), .ADDR_W(ADDR_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_kind (cfg_kind),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .mode     (target_mode),
        .en_vec   (en_vec)
    );

    lpm_periph_gate #(.NUM_PERIPH(NUM_PERIPH)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .safe    (safe),
        .en_vec  (en_vec),
        .ack     (periph_ack),
        .stop_req(periph_stop_req),
        .clk_en  (periph_clk_en),
        .pending (pending)
    );

    lpm_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .target_mode (target_mode),
        .pending     (pending),
        .cpu_halt_ack(cpu_halt_ack),
        .cpu_stop_ack(cpu_stop_ack),
        .wake        (wake),
        .load        (load),
        .safe        (safe),
        .cpu_halt_req(cpu_halt_req),
        .cpu_stop_req(cpu_stop_req),
        .core_clk_en (core_clk_en),
        .done        (done)
    );

    AST_NO_CPU_REQ_ON_PENDING: assert property (@(posedge clk) disable iff (rst)
        ($rose(cpu_halt_req) || $rose(cpu_stop_req)) |-> !$past(pending)); // R7

endmodule

// File: tb/tb_lpm_clk_seq.sv
module tb_lpm_clk_seq;

    localparam int N  = 12;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_kind = '0;
    logic [AW-1:0] cfg_addr = '0;
    logic [5:0]    cfg_wdata = '0;
    logic          start = 1'b0;
    logic [3:0]    target_mode = '0;
    logic          ack_on = 1'b0;
    logic [N-1:0]  periph_ack;
    logic          cpu_halt_ack = 1'b0;
    logic          cpu_stop_ack = 1'b0;
    logic          wake = 1'b0;
    logic [N-1:0]  periph_stop_req;
    logic [N-1:0]  periph_clk_en;
    logic          cpu_halt_req;
    logic          cpu_stop_req;
    logic          core_clk_en;
    logic          done;

    int checks = 0;
    int failures = 0;

    logic [5:0] m_run [8];
    logic [2:0] m_lp  [8];
    logic [2:0] m_rsel [N];
    logic [2:0] m_lsel [N];
    logic [N-1:0] exp_clk;
    logic [N-1:0] exp_req;

    assign periph_ack = {N{ack_on}} & periph_stop_req;

    always #4 clk = ~clk;

    lpm_clk_seq #(.NUM_PERIPH(N), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .start(start),
        .target_mode(target_mode), .periph_ack(periph_ack),
        .cpu_halt_ack(cpu_halt_ack), .cpu_stop_ack(cpu_stop_ack), .wake(wake),
        .periph_stop_req(periph_stop_req), .periph_clk_en(periph_clk_en),
        .cpu_halt_req(cpu_halt_req), .cpu_stop_req(cpu_stop_req),
        .core_clk_en(core_clk_en), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic en_of(input int p, input logic [3:0] m);
        if (m <= 4'd5) return m_run[m_rsel[p]][m];
        return m_lp[m_lsel[p]][m - 4'd6];
    endfunction

    task automatic cfg_write(input logic [1:0] k, input int a, input logic [5:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = k; cfg_addr = AW'(a); cfg_wdata = d;
        if (k == 2'd0) m_run[a] = d;
        else if (k == 2'd1) m_lp[a] = d[2:0];
        else begin m_rsel[a] = d[2:0]; m_lsel[a] = d[5:3]; end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic randomize_cfg();
        for (int s = 0; s < 8; s++) cfg_write(2'd0, s, 6'($urandom));
        for (int s = 0; s < 8; s++) cfg_write(2'd1, s, 6'($urandom));
        for (int p = 0; p < N; p++) cfg_write(2'd2, p, 6'($urandom)); // R11
    endtask

    task automatic run_transition(input logic [3:0] m, input int dly, input bit wrong_ack, input bit busy_start);
        logic [N-1:0] en;
        logic lp;
        bit pend;
        for (int p = 0; p < N; p++) en[p] = en_of(p, m);
        lp = (m >= 4'd6);
        @(negedge clk);
        ack_on = 1'b0; target_mode = m; start = 1'b1;
        for (int p = 0; p < N; p++) begin
            if (en[p]) begin exp_clk[p] = 1'b1; exp_req[p] = 1'b0; end
            else begin
                exp_req[p] = exp_req[p] | exp_clk[p];
                if (m == 4'd0) exp_clk[p] = 1'b0;
            end
        end
        @(negedge clk);
        start = 1'b0;
        chk("R3 stop_req after start", 32'(periph_stop_req), 32'(exp_req));
        chk(m == 4'd0 ? "R5 safe gating" : "R3 clk after start", 32'(periph_clk_en), 32'(exp_clk));
        pend = ((exp_req & exp_clk) != '0);
        if (pend) begin
            for (int c = 0; c < dly; c++) begin
                chk("R4 no gating before ack", 32'(periph_clk_en), 32'(exp_clk));
                chk("R6 no done while pending", 32'(done), 32'd0);
                chk("R7 no cpu req while pending", 32'({cpu_halt_req, cpu_stop_req}), 32'd0);
                @(negedge clk);
            end
        end
        ack_on = 1'b1;
        @(negedge clk);
        exp_clk = exp_clk & ~exp_req;
        chk("R4 gated after ack", 32'(periph_clk_en), 32'(exp_clk));
        if (!lp) begin
            chk("R6 done pulse", 32'(done), 32'd1);
            chk("R6 no cpu req", 32'({cpu_halt_req, cpu_stop_req}), 32'd0);
            chk("R6 core on", 32'(core_clk_en), 32'd1);
            @(negedge clk);
            chk("R6 done single", 32'(done), 32'd0);
        end else begin
            chk("R7 cpu req type", 32'({cpu_halt_req, cpu_stop_req}),
                (m == 4'd6) ? 32'd2 : 32'd1);
            chk("R7 no done yet", 32'(done), 32'd0);
            if (busy_start) begin
                target_mode = 4'd1; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                chk("R10 busy start ignored clk", 32'(periph_clk_en), 32'(exp_clk));
                chk("R10 busy start ignored req", 32'(periph_stop_req), 32'(exp_req));
            end
            if (wrong_ack) begin
                if (m == 4'd6) cpu_stop_ack = 1'b1; else cpu_halt_ack = 1'b1;
                @(negedge clk);
                cpu_stop_ack = 1'b0; cpu_halt_ack = 1'b0;
                chk("R8 wrong ack ignored", 32'(core_clk_en), 32'd1);
            end
            if (m == 4'd6) cpu_halt_ack = 1'b1; else cpu_stop_ack = 1'b1;
            @(negedge clk);
            cpu_stop_ack = 1'b0; cpu_halt_ack = 1'b0;
            chk("R8 core gated", 32'(core_clk_en), 32'd0);
            chk("R8 done pulse", 32'(done), 32'd1);
            @(negedge clk);
            chk("R8 done single", 32'(done), 32'd0);
            wake = 1'b1;
            @(negedge clk);
            wake = 1'b0;
            chk("R9 core restored", 32'(core_clk_en), 32'd1);
            chk("R9 cpu reqs cleared", 32'({cpu_halt_req, cpu_stop_req}), 32'd0);
            chk("R9 periph clocks held", 32'(periph_clk_en), 32'(exp_clk));
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5eed_0042);
        for (int s = 0; s < 8; s++) begin m_run[s] = '1; m_lp[s] = '1; end
        for (int p = 0; p < N; p++) begin m_rsel[p] = '0; m_lsel[p] = '0; end
        exp_clk = '1; exp_req = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 clk_en reset", 32'(periph_clk_en), 32'(exp_clk));
        chk("R1 stop_req reset", 32'(periph_stop_req), 32'd0);
        chk("R1 cpu reqs reset", 32'({cpu_halt_req, cpu_stop_req}), 32'd0);
        chk("R1 core reset", 32'(core_clk_en), 32'd1);
        chk("R1 done reset", 32'(done), 32'd0);
        // R2: all-enabled default config keeps everything on
        run_transition(4'd3, 2, 1'b0, 1'b0);

        randomize_cfg();
        // R10: invalid mode code is ignored
        @(negedge clk);
        target_mode = 4'd12; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R10 invalid code no done", 32'(done), 32'd0);
        chk("R10 invalid code clk", 32'(periph_clk_en), 32'(exp_clk));
        chk("R10 invalid code req", 32'(periph_stop_req), 32'(exp_req));

        // directed: disable everything then SAFE, HALT with wrong ack and busy start
        run_transition(4'd1, 3, 1'b0, 1'b0);
        run_transition(4'd0, 0, 1'b0, 1'b0);
        run_transition(4'd6, 2, 1'b1, 1'b1);
        run_transition(4'd7, 1, 1'b1, 1'b0);
        run_transition(4'd8, 4, 1'b0, 1'b1);
        for (int it = 0; it < 60; it++) begin
            if (it % 15 == 14) randomize_cfg();
            run_transition(4'($urandom_range(0, 8)), $urandom_range(0, 4),
                           1'($urandom), 1'($urandom));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule